// File: doc/BRIEF.md
# Burst Data-Transfer Target for a Shared Address/Data Bus

This block is the slave side of a clocked bus on which one set of lines carries first an address and then a stream of data words. A master opens a transaction by raising a frame line while it drives a command code and a word address. The target claims the transaction when the upper address bits match its window and the command is a read or a write. Data then moves one word per rising edge on which the master-ready and target-ready lines are both high. The address advances by one word after each completed transfer, so a burst may run for any length. The master marks its last word by lowering frame while that word is still pending.

On the other side the target talks to a simple local memory. The memory gives a ready flag. For reads it presents the word at the current address without delay. Writes are committed on a one-cycle strobe. While the memory is not ready, the target keeps target-ready low and so inserts wait states. The target can also end a transaction itself through a stop line. It disconnects when a burst reaches the last word of its window. It asks for a retry when the first word stalls for too long. It aborts when the address is its own but the command is not a read or a write.

The address/data lines and the target's control lines are driven by more than one agent, so the target leaves a dead cycle on them. It never drives read data in the cycle that follows an address. After a transaction it spends one cycle driving its control lines inactive before it releases them.

The controller has six states:
- IDLE: waits for an address phase.
- SKIP: a foreign transaction is in progress.
- TURN: the read turnaround cycle.
- DATA: data phases.
- BACKOFF: stop is held while the master winds down.
- RELEASE: control lines are driven inactive for one cycle.

Transitions:
- IDLE→SKIP: frame is high with a foreign address.
- IDLE→TURN: a read hits the window.
- IDLE→DATA: a write hits the window.
- IDLE→BACKOFF: another command hits the window (abort).
- SKIP→IDLE: frame and master-ready are both low.
- TURN→DATA: always, after one cycle.
- DATA→RELEASE: a transfer happens with frame low.
- DATA→BACKOFF: a transfer happens at the window end with frame still high, or the retry limit expires.
- BACKOFF→RELEASE: frame is low.
- RELEASE→IDLE: frame and master-ready are both low.

Top module: `bbt_target`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bus_sel, bus_trdy, bus_stop, bus_ctl_oe, bus_ad_oe and mem_strobe are all 0.
- R2: An address phase is the rising edge on which the target is idle and bus_frame is 1. The target claims it when bus_ad_in[DATA_W-1:ADDR_W] equals BASE_TAG and bus_cmd is 4'b0110 (read) or 4'b0111 (write). From the next cycle bus_sel and bus_ctl_oe are 1, and they stay 1 until the transaction ends.
- R3: A word is transferred, and mem_strobe is 1 in that cycle, only when bus_mrdy and bus_trdy are both 1. On a write, mem_wdata carries bus_ad_in and mem_wr is 1. A cycle with bus_mrdy low transfers nothing.
- R4: The first data phase uses the word address bus_ad_in[ADDR_W-1:0] from the address phase. mem_addr increases by one after every transfer.
- R5: For a read, bus_ad_oe and bus_trdy are 0 in the cycle after the address phase. From the following cycle on, bus_ad_oe is 1 and bus_ad_out carries mem_rdata.
- R6: During data phases bus_trdy equals mem_ready, so a memory that is not ready adds one wait state per cycle.
- R7: When a transfer happens with bus_frame at 0, the next cycle has bus_sel, bus_trdy and bus_stop at 0 with bus_ctl_oe at 1. The cycle after that, with bus_frame and bus_mrdy both 0, has bus_ctl_oe at 0.
- R8: In a data phase at word address all ones, bus_stop is 1 together with bus_trdy. If frame is still 1 after that transfer, bus_stop stays 1 with bus_trdy 0 and bus_sel 1 until frame falls.
- R9: If the first data phase sees mem_ready low for RETRY_WAITS consecutive cycles, bus_stop rises in the next cycle with bus_trdy 0 and bus_sel 1, and no word is transferred.
- R10: An in-window address with any other command gives, from the next cycle, bus_stop 1 with bus_sel 0 and bus_trdy 0, and no memory access. This lasts until frame falls.
- R11: A transaction whose upper address bits differ from BASE_TAG is ignored. bus_sel, bus_ctl_oe and mem_strobe stay 0 until both frame and master-ready have fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_frame | input | 1 | Transaction frame from master |
| bus_cmd | input | 4 | Command code during address phase |
| bus_ad_in | input | DATA_W | Shared address/data lines as seen by the target |
| bus_mrdy | input | 1 | Master ready |
| bus_ad_out | output | DATA_W | Read data driven onto the shared lines |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_sel | output | 1 | Target has claimed the transaction |
| bus_trdy | output | 1 | Target ready |
| bus_stop | output | 1 | Target requests end of transaction |
| bus_ctl_oe | output | 1 | Drive enable for bus_sel, bus_trdy, bus_stop |
| mem_addr | output | ADDR_W | Local memory word address |
| mem_wr | output | 1 | Local access is a write |
| mem_wdata | output | DATA_W | Local write data |
| mem_strobe | output | 1 | Commit one word this cycle |
| mem_rdata | input | DATA_W | Local read data for mem_addr |
| mem_ready | input | 1 | Local memory can complete a word |

## Verification
The claim, the read turnaround and the abort all show on the outputs in the cycle after the address edge, and the read data lines turn on one cycle later. target-ready, stop at the window end and the memory strobe are combinational within a data-phase cycle. The release cycle follows the final transfer edge by one cycle, and idle follows one more. A retry appears RETRY_WAITS edges after the address edge. The bench drives inputs just after each rising edge and samples every output at the falling edge of the cycle in which the rules above say it is due. A falling-edge monitor matches each strobe against the scoreboard queue in the same cycle as the transfer.

// File: rtl/bbt_pkg.sv
`timescale 1ns/1ps
package bbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_TURN,
        ST_DATA,
        ST_BACKOFF,
        ST_RELEASE
    } bbt_state_e;

    localparam logic [3:0] CMD_READ  = 4'b0110;
    localparam logic [3:0] CMD_WRITE = 4'b0111;

endpackage

// File: rtl/bbt_decode.sv
`timescale 1ns/1ps
module bbt_decode #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter logic [DATA_W-ADDR_W-1:0] BASE_TAG = '0
) (
    input  logic [DATA_W-1:0] ad,
    input  logic [3:0]        cmd,
    output logic              hit,
    output logic              is_rd,
    output logic              is_wr
);
    import bbt_pkg::*;

    always_comb begin
        hit   = (ad[DATA_W-1:ADDR_W] == BASE_TAG);
        is_rd = (cmd == CMD_READ);
        is_wr = (cmd == CMD_WRITE);
    end

endmodule

// File: rtl/bbt_addr_ctr.sv
`timescale 1ns/1ps
module bbt_addr_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + ADDR_W'(1);
        end
    end

    assign at_end = &addr;

endmodule

// File: rtl/bbt_wait_ctr.sv
`timescale 1ns/1ps
module bbt_wait_ctr #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (count_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expired = count_en && (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/bbt_target.sv
`timescale 1ns/1ps
module bbt_target #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter logic [DATA_W-ADDR_W-1:0] BASE_TAG = 26'h12_3456,
    parameter int RETRY_WAITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_frame,
    input  logic [3:0]        bus_cmd,
    input  logic [DATA_W-1:0] bus_ad_in,
    input  logic              bus_mrdy,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic              bus_sel,
    output logic              bus_trdy,
    output logic              bus_stop,
    output logic              bus_ctl_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_strobe,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    import bbt_pkg::*;

    bbt_state_e state_q, state_d;
    logic hit, cmd_rd, cmd_wr;
    logic is_wr_q, abort_q, first_q;
    logic claim, xfer, at_end, retry;
    logic [ADDR_W-1:0] addr;

    bbt_decode #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .BASE_TAG (BASE_TAG)
    ) u_decode (
        .ad    (bus_ad_in),
        .cmd   (bus_cmd),
        .hit   (hit),
        .is_rd (cmd_rd),
        .is_wr (cmd_wr)
    );

    bbt_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (claim),
        .load_val (bus_ad_in[ADDR_W-1:0]),
        .step     (xfer),
        .addr     (addr),
        .at_end   (at_end)
    );

    bbt_wait_ctr #(
        .LIMIT (RETRY_WAITS)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q != ST_DATA),
        .count_en ((state_q == ST_DATA) && first_q && !mem_ready),
        .expired  (retry)
    );

    assign claim = (state_q == ST_IDLE) && bus_frame && hit;
    assign xfer  = (state_q == ST_DATA) && mem_ready && bus_mrdy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transaction attributes captured at the address phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_wr_q <= 1'b0;
            abort_q <= 1'b0;
            first_q <= 1'b0;
        end else if (claim) begin
            is_wr_q <= cmd_wr;
            abort_q <= !cmd_rd && !cmd_wr;
            first_q <= 1'b1;
        end else if (xfer) begin
            first_q <= 1'b0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_frame) begin
                    if (!hit)        state_d = ST_SKIP;
                    else if (cmd_rd) state_d = ST_TURN;
                    else if (cmd_wr) state_d = ST_DATA;
                    else             state_d = ST_BACKOFF;
                end
            end
            ST_SKIP: begin
                if (!bus_frame && !bus_mrdy) state_d = ST_IDLE;
            end
            ST_TURN: begin
                state_d = ST_DATA;
            end
            ST_DATA: begin
                if (xfer) begin
                    if (!bus_frame)  state_d = ST_RELEASE;
                    else if (at_end) state_d = ST_BACKOFF;
                end else if (retry) begin
                    state_d = ST_BACKOFF;
                end
            end
            ST_BACKOFF: begin
                if (!bus_frame) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!bus_frame && !bus_mrdy) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_ctl_oe = 1'b0;
        bus_sel    = 1'b0;
        bus_trdy   = 1'b0;
        bus_stop   = 1'b0;
        bus_ad_oe  = 1'b0;
        mem_strobe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SKIP: ;
            ST_TURN: begin
                bus_ctl_oe = 1'b1;
                bus_sel    = 1'b1;
            end
            ST_DATA: begin
                bus_ctl_oe = 1'b1;
                bus_sel    = 1'b1;
                bus_trdy   = mem_ready;
                bus_stop   = at_end;
                bus_ad_oe  = !is_wr_q;
                mem_strobe = mem_ready && bus_mrdy;
            end
            ST_BACKOFF: begin
                bus_ctl_oe = 1'b1;
                bus_sel    = !abort_q;
                bus_stop   = 1'b1;
            end
            ST_RELEASE: begin
                bus_ctl_oe = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_ad_out = bus_ad_oe ? mem_rdata : '0;
    assign mem_addr   = addr;
    assign mem_wr     = is_wr_q;
    assign mem_wdata  = bus_ad_in;

endmodule

// File: rtl/bbt_target_chk.sv
`timescale 1ns/1ps
module bbt_target_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_frame,
    input logic              bus_mrdy,
    input logic              bus_sel,
    input logic              bus_trdy,
    input logic              bus_stop,
    input logic              bus_ctl_oe,
    input logic              bus_ad_oe,
    input logic              mem_strobe,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);
    p_claimed_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |-> (bus_sel && bus_ctl_oe));

    p_strobe_needs_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |-> bus_mrdy);

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    p_read_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_ctl_oe) && !mem_wr) |-> (!bus_ad_oe && !bus_trdy));

    p_ad_inside_ctl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ad_oe |-> bus_ctl_oe);

    p_wait_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> (!bus_trdy && !mem_strobe));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && !bus_frame) |=> (!bus_sel && !bus_trdy && !bus_stop && bus_ctl_oe));

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !bus_trdy && bus_frame) |=> bus_stop);

    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !bus_sel) |-> (!bus_trdy && !mem_strobe));

endmodule

bind bbt_target bbt_target_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bbt_target_bench.sv
`timescale 1ns/1ps
module bbt_target_bench;

    localparam int DW = 32;
    localparam int AW = 6;
    localparam int WAITS = 4;
    localparam logic [DW-AW-1:0] TAG = 26'h12_3456;

    typedef struct packed {
        logic          is_wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_n;
    logic bus_frame = 1'b0;
    logic [3:0] bus_cmd = 4'h0;
    logic [DW-1:0] bus_ad_in = '0;
    logic bus_mrdy = 1'b0;
    logic [DW-1:0] bus_ad_out;
    logic bus_ad_oe, bus_sel, bus_trdy, bus_stop, bus_ctl_oe;
    logic [AW-1:0] mem_addr;
    logic mem_wr, mem_strobe;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic mem_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 1'b0;
    int rdy_mode = 0;
    int cyc = 0;

    logic [DW-1:0] mem_model [1 << AW];
    logic [DW-1:0] exp_mem   [1 << AW];
    sb_item_t sb_q [$];

    always #10 clk = ~clk;

    bbt_target #(
        .DATA_W(DW), .ADDR_W(AW), .BASE_TAG(TAG), .RETRY_WAITS(WAITS)
    ) u_bbt_target (
        .clk(clk), .rst_n(rst_n), .bus_frame(bus_frame), .bus_cmd(bus_cmd),
        .bus_ad_in(bus_ad_in), .bus_mrdy(bus_mrdy), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_sel(bus_sel), .bus_trdy(bus_trdy),
        .bus_stop(bus_stop), .bus_ctl_oe(bus_ctl_oe), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_strobe(mem_strobe),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [DW-1:0] init_word(input int i);
        return 32'hC0DE_0000 + 32'(i * 17);
    endfunction

    function automatic logic [DW-1:0] wr_word(input logic [AW-1:0] a, input int i);
        return 32'hA500_0000 + (32'(a) << 8) + 32'(i);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        end
    endtask

    // local memory model
    assign mem_rdata = mem_model[mem_addr];
    always @(posedge clk) begin
        if (rst_n && mem_strobe && mem_wr) mem_model[mem_addr] <= mem_wdata;
    end

    // memory readiness pattern
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            case (rdy_mode)
                0: mem_ready = 1'b1;
                1: mem_ready = (cyc % 4) != 0;
                default: mem_ready = 1'b0;
            endcase
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        sb_item_t it;
        if (rst_n && mem_strobe) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R3 unexpected strobe", {26'h0, mem_addr}, '0);
            end else begin
                it = sb_q.pop_front();
                chk(mem_addr == it.addr, "R4 transfer address", {26'h0, mem_addr}, {26'h0, it.addr});
                chk(mem_wr == it.is_wr, "R3 transfer direction", {31'h0, mem_wr}, {31'h0, it.is_wr});
                if (it.is_wr)
                    chk(mem_wdata == it.data, "R3 write data", mem_wdata, it.data);
                else
                    chk(bus_ad_oe && bus_ad_out == it.data, "R5 read data", bus_ad_out, it.data);
            end
        end
    end

    task automatic release_checks(input string tag);
        @(negedge clk);
        chk(!bus_sel && !bus_trdy && !bus_stop && bus_ctl_oe, {"R7 release cycle ", tag},
            {28'h0, bus_sel, bus_trdy, bus_stop, bus_ctl_oe}, 32'h1);
        @(negedge clk);
        chk(!bus_ctl_oe, {"R7 idle after release ", tag}, {31'h0, bus_ctl_oe}, 32'h0);
        chk(sb_q.size() == 0, {"R3 all expected words moved ", tag}, 32'(sb_q.size()), 32'h0);
    endtask

    task automatic burst(input bit wr, input logic [AW-1:0] a, input int n, input bit mwait);
        int done = 0;
        int k = 0;
        bit x;
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] ai = a + AW'(i);
            if (wr) begin
                exp_mem[ai] = wr_word(a, i);
                sb_q.push_back('{1'b1, ai, wr_word(a, i)});
            end else begin
                sb_q.push_back('{1'b0, ai, exp_mem[ai]});
            end
        end
        @(posedge clk); #1;
        bus_frame = 1'b1;
        bus_cmd   = wr ? 4'b0111 : 4'b0110;
        bus_ad_in = {TAG, a};
        bus_mrdy  = 1'b0;
        @(posedge clk); #1;
        bus_frame = (n > 1);
        bus_mrdy  = 1'b1;
        bus_ad_in = wr ? wr_word(a, 0) : '0;
        while (done < n) begin
            @(negedge clk);
            if (k == 0) begin
                chk(bus_sel && bus_ctl_oe, "R2 claim", {30'h0, bus_sel, bus_ctl_oe}, 32'h3);
                if (!wr) chk(!bus_ad_oe && !bus_trdy, "R5 turnaround", {30'h0, bus_ad_oe, bus_trdy}, 32'h0);
            end
            if (k == 1 && !wr) chk(bus_ad_oe, "R5 read drive", {31'h0, bus_ad_oe}, 32'h1);
            if (k >= 1) chk(bus_trdy == mem_ready, "R6 wait state", {31'h0, bus_trdy}, {31'h0, mem_ready});
            x = bus_trdy && bus_mrdy;
            @(posedge clk); #1;
            k++;
            if (x) begin
                done++;
                if (done == n) begin
                    bus_frame = 1'b0;
                    bus_mrdy  = 1'b0;
                end else begin
                    bus_ad_in = wr ? wr_word(a, done) : '0;
                    bus_frame = (done < n - 1);
                    if (mwait && done == 1) bus_mrdy = 1'b0;
                end
            end else if (!bus_mrdy) begin
                bus_mrdy = 1'b1;
            end
        end
        release_checks(wr ? "write" : "read");
    endtask

    task automatic foreign_burst();
        @(posedge clk); #1;
        bus_frame = 1'b1;
        bus_cmd   = 4'b0111;
        bus_ad_in = {~TAG, 6'd3};
        @(posedge clk); #1;
        bus_mrdy  = 1'b1;
        bus_ad_in = 32'hDEAD_BEEF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!bus_sel && !bus_ctl_oe && !mem_strobe, "R11 foreign ignored",
                {29'h0, bus_sel, bus_ctl_oe, mem_strobe}, 32'h0);
            @(posedge clk); #1;
            if (i == 2) bus_frame = 1'b0;
        end
        bus_mrdy = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic disconnect_burst();
        exp_mem[62] = wr_word(6'd62, 0);
        exp_mem[63] = wr_word(6'd62, 1);
        sb_q.push_back('{1'b1, 6'd62, wr_word(6'd62, 0)});
        sb_q.push_back('{1'b1, 6'd63, wr_word(6'd62, 1)});
        @(posedge clk); #1;
        bus_frame = 1'b1; bus_cmd = 4'b0111; bus_ad_in = {TAG, 6'd62};
        @(posedge clk); #1;
        bus_mrdy = 1'b1; bus_ad_in = wr_word(6'd62, 0);
        @(negedge clk);
        chk(!bus_stop, "R8 no stop before window end", {31'h0, bus_stop}, 32'h0);
        @(posedge clk); #1;
        bus_ad_in = wr_word(6'd62, 1);
        @(negedge clk);
        chk(bus_stop && bus_trdy, "R8 stop with last word", {30'h0, bus_stop, bus_trdy}, 32'h3);
        @(posedge clk); #1;
        bus_ad_in = wr_word(6'd62, 2);
        @(negedge clk);
        chk(bus_stop && !bus_trdy && bus_sel, "R8 stop held",
            {29'h0, bus_stop, bus_trdy, bus_sel}, 32'h5);
        @(posedge clk); #1;
        bus_frame = 1'b0; bus_mrdy = 1'b0;
        @(negedge clk);
        chk(bus_stop, "R8 stop until frame falls", {31'h0, bus_stop}, 32'h1);
        release_checks("disconnect");
    endtask

    task automatic retry_burst();
        rdy_mode = 2;
        @(posedge clk); #1;
        bus_frame = 1'b1; bus_cmd = 4'b0111; bus_ad_in = {TAG, 6'd10};
        @(posedge clk); #1;
        bus_frame = 1'b0; bus_mrdy = 1'b1; bus_ad_in = 32'h1234_5678;
        for (int k = 1; k <= WAITS; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < WAITS)
                chk(!bus_stop && !bus_trdy, "R9 waiting before retry", {30'h0, bus_stop, bus_trdy}, 32'h0);
            else
                chk(bus_stop && bus_sel && !bus_trdy, "R9 retry stop",
                    {29'h0, bus_stop, bus_sel, bus_trdy}, 32'h6);
        end
        bus_mrdy = 1'b0;
        release_checks("retry");
        chk(mem_model[10] == exp_mem[10], "R9 no write on retry", mem_model[10], exp_mem[10]);
        rdy_mode = 0;
    endtask

    task automatic abort_burst();
        @(posedge clk); #1;
        bus_frame = 1'b1; bus_cmd = 4'b0011; bus_ad_in = {TAG, 6'd20};
        @(posedge clk); #1;
        bus_mrdy = 1'b1; bus_ad_in = 32'h0BAD_0BAD;
        @(negedge clk);
        chk(bus_stop && !bus_sel && !bus_trdy, "R10 abort",
            {29'h0, bus_stop, bus_sel, bus_trdy}, 32'h4);
        @(posedge clk); #1;
        @(negedge clk);
        chk(bus_stop && !bus_sel, "R10 abort held", {30'h0, bus_stop, bus_sel}, 32'h2);
        bus_frame = 1'b0; bus_mrdy = 1'b0;
        release_checks("abort");
        chk(mem_model[20] == exp_mem[20], "R10 memory untouched", mem_model[20], exp_mem[20]);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin
            mem_model[i] = init_word(i);
            exp_mem[i]   = init_word(i);
        end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!bus_sel && !bus_trdy && !bus_stop && !bus_ctl_oe && !bus_ad_oe && !mem_strobe,
            "R1 reset outputs", {26'h0, bus_sel, bus_trdy, bus_stop, bus_ctl_oe, bus_ad_oe, mem_strobe}, 32'h0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_ctl_oe && !bus_sel, "R1 after reset", {30'h0, bus_ctl_oe, bus_sel}, 32'h0);

        burst(1'b1, 6'd4, 5, 1'b0);
        burst(1'b0, 6'd4, 5, 1'b0);
        burst(1'b0, 6'd30, 1, 1'b0);
        burst(1'b1, 6'd40, 1, 1'b0);
        rdy_mode = 1;
        burst(1'b1, 6'd12, 6, 1'b1);
        burst(1'b0, 6'd12, 6, 1'b1);
        burst(1'b0, 6'd0, 3, 1'b0);
        rdy_mode = 0;
        foreign_burst();
        burst(1'b0, 6'd40, 2, 1'b0);
        disconnect_burst();
        burst(1'b0, 6'd61, 2, 1'b0);
        retry_burst();
        abort_burst();
        burst(1'b0, 6'd10, 1, 1'b0);

        repeat (4) @(posedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        report();
        $finish;
    end

endmodule